// File: doc/BRIEF.md
# CPU Register File with Byte and Pair Views

This block holds the architectural registers of a small 8-bit CPU core: eight byte registers (accumulator, six general registers and the flag register) plus a 16-bit program counter and a 16-bit stack pointer. A datapath reads any byte register or any of four 16-bit pair views combinationally. It writes them on the rising clock edge through one byte write port and one pair write port. The pair views have no storage of their own and are assembled from the byte registers.

A dedicated flag port sets or clears the zero, subtract, half-carry and carry bits one at a time. The lower nibble of the flag register never holds anything but zero, whichever path writes it. The program counter and stack pointer each have their own load and step controls and wrap at 16 bits. The block stores values and enforces these rules. Arithmetic, decode and memory access belong to the surrounding core.

Top module: `cpu_regfile`

## Requirements
- R1: While rst_ni is low, and on the first sample after it rises, every byte register, every pair view, the flag outputs, PC and SP read zero.
- R2: Byte select encoding is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A. A byte write stores byte_wdata_i in the selected register at the rising edge, and byte_rdata_o shows the register chosen by byte_rsel_i combinationally.
- R3: Pair select encoding is 0=BC, 1=DE, 2=HL, 3=AF, where the first-named register is bits 15:8 and the second is bits 7:0. A pair write updates both bytes, and a pair read concatenates them, so a pair and its byte registers always agree.
- R4: Bits 3:0 of F read zero at all times. A write to F through the byte port or through the AF pair stores the value ANDed with 0xF0 (0xFF gives 0xF0, 0x0F gives 0x00).
- R5: Flag positions in F are Z bit 7, N bit 6, H bit 5, C bit 4. flag_we_i and flag_val_i index them as [3]=Z, [2]=N, [1]=H, [0]=C, and flags_o reports F[7:4] in the same order. An enabled flag takes its value at the edge, and a disabled flag keeps its value.
- R6: When a flag-port update and a byte or AF write to F happen in the same cycle, the flag port decides every bit it enables, and the full write decides the remaining upper bits.
- R7: When the byte write and the pair write target the same register in one cycle, the pair data is stored. When they target different registers, both writes take effect.
- R8: PC loads pc_ldata_i when pc_ld_i is high. Otherwise it adds 1 when pc_inc_i is high, wrapping 0xFFFF to 0x0000.
- R9: SP loads sp_ldata_i when sp_ld_i is high. Otherwise it adds 2 when only sp_inc_i is high, subtracts 2 when only sp_dec_i is high, and holds when both or neither are high. All results wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_rsel_i | input | 3 | Byte read select |
| byte_rdata_o | output | 8 | Selected byte register |
| pair_rsel_i | input | 2 | Pair read select |
| pair_rdata_o | output | 16 | Selected pair view |
| byte_we_i | input | 1 | Byte write enable |
| byte_wsel_i | input | 3 | Byte write select |
| byte_wdata_i | input | 8 | Byte write data |
| pair_we_i | input | 1 | Pair write enable |
| pair_wsel_i | input | 2 | Pair write select |
| pair_wdata_i | input | 16 | Pair write data |
| flag_we_i | input | 4 | Per-flag write enables {Z,N,H,C} |
| flag_val_i | input | 4 | Per-flag values {Z,N,H,C} |
| flags_o | output | 4 | Current flags {Z,N,H,C} |
| pc_ld_i | input | 1 | PC load |
| pc_inc_i | input | 1 | PC increment by 1 |
| pc_ldata_i | input | 16 | PC load value |
| pc_o | output | 16 | Program counter |
| sp_ld_i | input | 1 | SP load |
| sp_inc_i | input | 1 | SP increment by 2 |
| sp_dec_i | input | 1 | SP decrement by 2 |
| sp_ldata_i | input | 16 | SP load value |
| sp_o | output | 16 | Stack pointer |

## Verification
Every read path is combinational from stored state. A corrupted register therefore shows up on the byte or pair output in the same half cycle that its select points at it, and the bench sweeps all eight byte selects and all four pair selects on every clock. A bad write merge, such as the wrong winner on a byte/pair collision or a flag bit lost to a full F write, is visible one edge after the write. A wrong F mask shows up as a nonzero low nibble on both the byte view and the AF view. Pointer step errors show on pc_o or sp_o one edge after the control is raised.

// File: rtl/cpu_rf_pkg.sv
`timescale 1ns/1ps
package cpu_rf_pkg;
  localparam int BYTE_W   = 8;
  localparam int NREG     = 8;
  localparam int SEL_W    = $clog2(NREG);
  localparam int NPAIR    = 4;
  localparam int PSEL_W   = $clog2(NPAIR);
  localparam int PAIR_W   = 2 * BYTE_W;
  localparam int NFLAG    = 4;
  localparam int FLAG_LSB = BYTE_W - NFLAG;
  localparam int PTR_W    = 16;

  localparam logic [SEL_W-1:0] RS_B = 3'd0;
  localparam logic [SEL_W-1:0] RS_C = 3'd1;
  localparam logic [SEL_W-1:0] RS_D = 3'd2;
  localparam logic [SEL_W-1:0] RS_E = 3'd3;
  localparam logic [SEL_W-1:0] RS_H = 3'd4;
  localparam logic [SEL_W-1:0] RS_L = 3'd5;
  localparam logic [SEL_W-1:0] RS_F = 3'd6;
  localparam logic [SEL_W-1:0] RS_A = 3'd7;

  localparam logic [PSEL_W-1:0] PS_AF = 2'd3;

  localparam logic [BYTE_W-1:0] F_KEEP = 8'hF0;

  typedef logic [NREG-1:0][BYTE_W-1:0] reg_bank_t;

  // AF is the odd one out; the others map to consecutive byte slots
  function automatic logic [SEL_W-1:0] pair_hi(input logic [PSEL_W-1:0] p);
    return (p == PS_AF) ? RS_A : {p, 1'b0};
  endfunction

  function automatic logic [SEL_W-1:0] pair_lo(input logic [PSEL_W-1:0] p);
    return (p == PS_AF) ? RS_F : {p, 1'b1};
  endfunction
endpackage

// File: rtl/rf_flag_merge.sv
`timescale 1ns/1ps
module rf_flag_merge
  import cpu_rf_pkg::*;
(
  input  logic [BYTE_W-1:0] raw_i,
  input  logic [NFLAG-1:0]  flag_we_i,
  input  logic [NFLAG-1:0]  flag_val_i,
  output logic [BYTE_W-1:0] f_o
);
  always_comb begin
    f_o = raw_i & F_KEEP;
    for (int i = 0; i < NFLAG; i++) begin
      if (flag_we_i[i]) f_o[FLAG_LSB+i] = flag_val_i[i];
    end
  end
endmodule

// File: rtl/rf_byte_bank.sv
`timescale 1ns/1ps
module rf_byte_bank
  import cpu_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [SEL_W-1:0]  byte_wsel_i,
  input  logic [BYTE_W-1:0] byte_wdata_i,
  input  logic              pair_we_i,
  input  logic [PSEL_W-1:0] pair_wsel_i,
  input  logic [PAIR_W-1:0] pair_wdata_i,
  input  logic [NFLAG-1:0]  flag_we_i,
  input  logic [NFLAG-1:0]  flag_val_i,
  output reg_bank_t         regs_o
);
  logic [SEL_W-1:0] hi_sel, lo_sel;
  assign hi_sel = pair_hi(pair_wsel_i);
  assign lo_sel = pair_lo(pair_wsel_i);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [BYTE_W-1:0] merged, d, q;

    // pair write is applied last so it wins a collision
    always_comb begin
      merged = q;
      if (byte_we_i && byte_wsel_i == SEL_W'(k)) merged = byte_wdata_i;
      if (pair_we_i && hi_sel == SEL_W'(k)) merged = pair_wdata_i[PAIR_W-1:BYTE_W];
      if (pair_we_i && lo_sel == SEL_W'(k)) merged = pair_wdata_i[BYTE_W-1:0];
    end

    if (k == int'(RS_F)) begin : g_flag
      rf_flag_merge u_merge (
        .raw_i      (merged),
        .flag_we_i  (flag_we_i),
        .flag_val_i (flag_val_i),
        .f_o        (d)
      );
    end else begin : g_plain
      assign d = merged;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign regs_o[k] = q;
  end
endmodule

// File: rtl/rf_ptr_reg.sv
`timescale 1ns/1ps
module rf_ptr_reg #(
  parameter int W    = 16,
  parameter int UP   = 1,
  parameter int DOWN = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ldata_i,
  input  logic         up_i,
  input  logic         down_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (ld_i)                 d = ldata_i;
    else if (up_i && !down_i) d = q + W'(UP);
    else if (down_i && !up_i) d = q - W'(DOWN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign val_o = q;
endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/1ps
module cpu_regfile
  import cpu_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  byte_rsel_i,
  output logic [BYTE_W-1:0] byte_rdata_o,
  input  logic [PSEL_W-1:0] pair_rsel_i,
  output logic [PAIR_W-1:0] pair_rdata_o,
  input  logic              byte_we_i,
  input  logic [SEL_W-1:0]  byte_wsel_i,
  input  logic [BYTE_W-1:0] byte_wdata_i,
  input  logic              pair_we_i,
  input  logic [PSEL_W-1:0] pair_wsel_i,
  input  logic [PAIR_W-1:0] pair_wdata_i,
  input  logic [NFLAG-1:0]  flag_we_i,
  input  logic [NFLAG-1:0]  flag_val_i,
  output logic [NFLAG-1:0]  flags_o,
  input  logic              pc_ld_i,
  input  logic              pc_inc_i,
  input  logic [PTR_W-1:0]  pc_ldata_i,
  output logic [PTR_W-1:0]  pc_o,
  input  logic              sp_ld_i,
  input  logic              sp_inc_i,
  input  logic              sp_dec_i,
  input  logic [PTR_W-1:0]  sp_ldata_i,
  output logic [PTR_W-1:0]  sp_o
);
  reg_bank_t regs;

  rf_byte_bank u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_we_i    (byte_we_i),
    .byte_wsel_i  (byte_wsel_i),
    .byte_wdata_i (byte_wdata_i),
    .pair_we_i    (pair_we_i),
    .pair_wsel_i  (pair_wsel_i),
    .pair_wdata_i (pair_wdata_i),
    .flag_we_i    (flag_we_i),
    .flag_val_i   (flag_val_i),
    .regs_o       (regs)
  );

  rf_ptr_reg #(.W(PTR_W), .UP(1), .DOWN(0)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (pc_ld_i),
    .ldata_i (pc_ldata_i),
    .up_i    (pc_inc_i),
    .down_i  (1'b0),
    .val_o   (pc_o)
  );

  rf_ptr_reg #(.W(PTR_W), .UP(2), .DOWN(2)) u_sp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (sp_ld_i),
    .ldata_i (sp_ldata_i),
    .up_i    (sp_inc_i),
    .down_i  (sp_dec_i),
    .val_o   (sp_o)
  );

  assign byte_rdata_o = regs[byte_rsel_i];
  assign pair_rdata_o = {regs[pair_hi(pair_rsel_i)], regs[pair_lo(pair_rsel_i)]};
  assign flags_o      = regs[RS_F][BYTE_W-1:FLAG_LSB];
endmodule

// File: rtl/cpu_regfile_chk.sv
`timescale 1ns/1ps
module cpu_regfile_chk
  import cpu_rf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  byte_rsel_i,
  input logic [BYTE_W-1:0] byte_rdata_o,
  input logic [PSEL_W-1:0] pair_rsel_i,
  input logic [PAIR_W-1:0] pair_rdata_o,
  input logic              byte_we_i,
  input logic [SEL_W-1:0]  byte_wsel_i,
  input logic [BYTE_W-1:0] byte_wdata_i,
  input logic              pair_we_i,
  input logic [PSEL_W-1:0] pair_wsel_i,
  input logic [PAIR_W-1:0] pair_wdata_i,
  input logic [NFLAG-1:0]  flag_we_i,
  input logic [NFLAG-1:0]  flag_val_i,
  input logic [NFLAG-1:0]  flags_o,
  input logic              pc_ld_i,
  input logic              pc_inc_i,
  input logic [PTR_W-1:0]  pc_ldata_i,
  input logic [PTR_W-1:0]  pc_o,
  input logic              sp_ld_i,
  input logic              sp_inc_i,
  input logic              sp_dec_i,
  input logic [PTR_W-1:0]  sp_ldata_i,
  input logic [PTR_W-1:0]  sp_o
);
  assert_af_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_rsel_i == PS_AF) |-> (pair_rdata_o[3:0] == 4'h0));

  assert_f_byte_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_rsel_i == RS_F) |-> (byte_rdata_o[3:0] == 4'h0));

  assert_zero_flag_port_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i[3] |=> (flags_o[3] == $past(flag_val_i[3])));

  assert_carry_flag_port_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i[0] |=> (flags_o[0] == $past(flag_val_i[0])));

  assert_pc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_inc_i && !pc_ld_i) |=> (pc_o == $past(pc_o) + 16'd1));

  assert_pc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_inc_i && !pc_ld_i) |=> $stable(pc_o));

  assert_sp_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_ld_i |=> (sp_o == $past(sp_ldata_i)));

  assert_sp_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_dec_i && !sp_inc_i && !sp_ld_i) |=> (sp_o == $past(sp_o) - 16'd2));

  assert_sp_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_dec_i && sp_inc_i && !sp_ld_i) |=> $stable(sp_o));
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (.*);

// File: tb/cpu_regfile_test.sv
`timescale 1ns/1ps
module cpu_regfile_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  byte_rsel = '0;
  logic [7:0]  byte_rdata;
  logic [1:0]  pair_rsel = '0;
  logic [15:0] pair_rdata;
  logic        byte_we = 1'b0;
  logic [2:0]  byte_wsel = '0;
  logic [7:0]  byte_wdata = '0;
  logic        pair_we = 1'b0;
  logic [1:0]  pair_wsel = '0;
  logic [15:0] pair_wdata = '0;
  logic [3:0]  flag_we = '0;
  logic [3:0]  flag_val = '0;
  logic [3:0]  flags;
  logic        pc_ld = 1'b0, pc_inc = 1'b0;
  logic [15:0] pc_ldata = '0, pc;
  logic        sp_ld = 1'b0, sp_inc = 1'b0, sp_dec = 1'b0;
  logic [15:0] sp_ldata = '0, sp;

  int checks = 0;
  int failures = 0;
  logic [7:0]  m_reg [8];
  logic [15:0] m_pc, m_sp;

  always #4 clk = ~clk;

  cpu_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .byte_rsel_i(byte_rsel), .byte_rdata_o(byte_rdata),
    .pair_rsel_i(pair_rsel), .pair_rdata_o(pair_rdata),
    .byte_we_i(byte_we), .byte_wsel_i(byte_wsel), .byte_wdata_i(byte_wdata),
    .pair_we_i(pair_we), .pair_wsel_i(pair_wsel), .pair_wdata_i(pair_wdata),
    .flag_we_i(flag_we), .flag_val_i(flag_val), .flags_o(flags),
    .pc_ld_i(pc_ld), .pc_inc_i(pc_inc), .pc_ldata_i(pc_ldata), .pc_o(pc),
    .sp_ld_i(sp_ld), .sp_inc_i(sp_inc), .sp_dec_i(sp_dec), .sp_ldata_i(sp_ldata), .sp_o(sp)
  );

  function automatic int hi_of(input int p);
    return (p == 3) ? 7 : 2 * p;
  endfunction
  function automatic int lo_of(input int p);
    return (p == 3) ? 6 : 2 * p + 1;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // model of one edge, written from the requirements
  task automatic model_edge();
    logic [7:0] nr [8];
    for (int i = 0; i < 8; i++) nr[i] = m_reg[i];
    if (byte_we) nr[byte_wsel] = byte_wdata;
    if (pair_we) begin
      nr[hi_of(pair_wsel)] = pair_wdata[15:8];
      nr[lo_of(pair_wsel)] = pair_wdata[7:0];
    end
    nr[6] = nr[6] & 8'hF0;
    for (int i = 0; i < 4; i++) if (flag_we[i]) nr[6][4+i] = flag_val[i];
    for (int i = 0; i < 8; i++) m_reg[i] = nr[i];
    if (pc_ld) m_pc = pc_ldata;
    else if (pc_inc) m_pc = m_pc + 16'd1;
    if (sp_ld) m_sp = sp_ldata;
    else if (sp_inc && !sp_dec) m_sp = m_sp + 16'd2;
    else if (sp_dec && !sp_inc) m_sp = m_sp - 16'd2;
  endtask

  task automatic compare_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      byte_rsel = 3'(s);
      #0.1;
      chk(tag != "" ? tag : (s == 6 ? "R4" : "R2"), {8'h00, byte_rdata}, {8'h00, m_reg[s]});
    end
    for (int p = 0; p < 4; p++) begin
      pair_rsel = 2'(p);
      #0.1;
      chk(tag != "" ? tag : "R3", pair_rdata, {m_reg[hi_of(p)], m_reg[lo_of(p)]});
    end
    chk(tag != "" ? tag : "R5", {12'h000, flags}, {12'h000, m_reg[6][7:4]});
    chk(tag != "" ? tag : "R8", pc, m_pc);
    chk(tag != "" ? tag : "R9", sp, m_sp);
  endtask

  task automatic quiet();
    byte_we = 0; pair_we = 0; flag_we = '0; pc_ld = 0; pc_inc = 0;
    sp_ld = 0; sp_inc = 0; sp_dec = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_ni) model_edge();
    @(negedge clk);
    compare_all("");
    quiet();
  endtask

  task automatic peek_byte(input string req, input int s, input logic [7:0] exp);
    byte_rsel = 3'(s);
    #0.1;
    chk(req, {8'h00, byte_rdata}, {8'h00, exp});
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 50000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = '0; m_sp = '0;
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2: byte write into A and L
    byte_we = 1; byte_wsel = 3'd7; byte_wdata = 8'h12; tick();
    peek_byte("R2", 7, 8'h12);
    byte_we = 1; byte_wsel = 3'd5; byte_wdata = 8'hFE; tick();

    // R3: pair writes to BC and HL
    pair_we = 1; pair_wsel = 2'd0; pair_wdata = 16'h1234; tick();
    peek_byte("R3", 0, 8'h12);
    peek_byte("R3", 1, 8'h34);
    pair_we = 1; pair_wsel = 2'd2; pair_wdata = 16'hBEEF; tick();

    // R4: F mask through byte port and AF
    byte_we = 1; byte_wsel = 3'd6; byte_wdata = 8'hFF; tick();
    peek_byte("R4", 6, 8'hF0);
    byte_we = 1; byte_wsel = 3'd6; byte_wdata = 8'h0F; tick();
    peek_byte("R4", 6, 8'h00);
    pair_we = 1; pair_wsel = 2'd3; pair_wdata = 16'hABCD; tick();
    pair_rsel = 2'd3; #0.1; chk("R4", pair_rdata, 16'hABC0);

    // R5: set Z only, then clear C only
    flag_we = 4'b1000; flag_val = 4'b1000; tick();
    chk("R5", {12'h0, flags}, 16'h000C);
    flag_we = 4'b0001; flag_val = 4'b0000; tick();
    chk("R5", {12'h0, flags}, 16'h000C);

    // R6: flag port beats byte and AF writes of F
    byte_we = 1; byte_wsel = 3'd6; byte_wdata = 8'h00;
    flag_we = 4'b1000; flag_val = 4'b1000; tick();
    peek_byte("R6", 6, 8'h80);
    pair_we = 1; pair_wsel = 2'd3; pair_wdata = 16'h00FF;
    flag_we = 4'b0001; flag_val = 4'b0000; tick();
    peek_byte("R6", 6, 8'hE0);

    // R7: collision on C, then disjoint targets
    byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'h55;
    pair_we = 1; pair_wsel = 2'd0; pair_wdata = 16'h9988; tick();
    peek_byte("R7", 1, 8'h88);
    byte_we = 1; byte_wsel = 3'd2; byte_wdata = 8'h77;
    pair_we = 1; pair_wsel = 2'd2; pair_wdata = 16'h4321; tick();
    peek_byte("R7", 2, 8'h77);
    peek_byte("R7", 4, 8'h43);

    // R8: PC wrap and load priority
    pc_ld = 1; pc_ldata = 16'hFFFF; tick();
    pc_inc = 1; tick();
    chk("R8", pc, 16'h0000);
    pc_ld = 1; pc_inc = 1; pc_ldata = 16'h0100; tick();
    chk("R8", pc, 16'h0100);

    // R9: SP wrap in both directions, hold when both steps
    sp_ld = 1; sp_ldata = 16'h0001; tick();
    sp_dec = 1; tick();
    chk("R9", sp, 16'hFFFF);
    sp_inc = 1; tick();
    chk("R9", sp, 16'h0001);
    sp_inc = 1; sp_dec = 1; tick();
    chk("R9", sp, 16'h0001);

    // mixed random traffic against the model
    for (int n = 0; n < 400; n++) begin
      byte_we = 1'($urandom); byte_wsel = 3'($urandom); byte_wdata = 8'($urandom);
      pair_we = 1'($urandom); pair_wsel = 2'($urandom); pair_wdata = 16'($urandom);
      flag_we = 4'($urandom); flag_val = 4'($urandom);
      pc_ld = (($urandom % 8) == 0); pc_inc = 1'($urandom); pc_ldata = 16'($urandom);
      sp_ld = (($urandom % 8) == 0); sp_inc = 1'($urandom); sp_dec = 1'($urandom);
      sp_ldata = 16'($urandom);
      tick();
    end

    summary();
    $finish;
  end
endmodule